// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits in the read path of a byte-alterable nonvolatile memory. While the write controller reports an internal programming cycle in progress, it replaces ordinary read data with a status word. A host can then find the end of the cycle by reading the memory, with no separate ready pin. Once the cycle has ended, reads return the true array contents again.

The status word carries two indicators at once. The top bit is the complement of the most significant bit of the last byte loaded. The next bit is a flag that inverts after each completed read access. The remaining low bits read as zero. A host can poll either indicator: it can compare the top bit against the value it wrote, or it can watch for two consecutive reads that agree in the toggle bit.

Chip select and output enable are active low and are sampled on the clock. The data path registers its outputs. A read is therefore visible one cycle after the edge at which both selects are sampled low. The array read data, the busy flag and the last written top bit come from neighbouring logic. Address decoding stays in that logic, because the status word is returned for any address.

Top module: `poll_status_resp`

## Requirements
- R1: `dout_oe_o` is 1 in the cycle after a clock edge at which `ce_ni` and `oe_ni` are both sampled 0, and is 0 after any edge at which either is sampled 1 or reset is active.
- R2: Whenever `dout_oe_o` is 0, `dout_o` is all zeros, standing in for a high-impedance bus.
- R3: For a read sampled while `busy_i` is 1, bit 7 (the top bit) of `dout_o` is the inverse of `last_msb_i` sampled at the same edge, whatever the address.
- R4: For reads sampled while `busy_i` is 1, bit 6 holds the toggle flag. The flag keeps its value for the whole of one access. It inverts once when an access ends, which is the first edge at which the read condition is no longer sampled, provided `busy_i` is 1 at that edge. Its value after reset is unspecified.
- R5: For a read sampled while `busy_i` is 1, bits 5 down to 0 of `dout_o` are zero.
- R6: For a read sampled while `busy_i` is 0, `dout_o` equals `array_rdata_i` sampled at the same edge, in all bits. This also holds when busy drops in the middle of an access.
- R7: An access that ends while `busy_i` is 0 leaves the toggle flag unchanged. The next busy-period read shows the same bit 6 as the last busy-period read before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| busy_i | input | 1 | Internal programming cycle in progress |
| last_msb_i | input | 1 | Top bit of the last byte loaded |
| array_rdata_i | input | DATA_W | True array read data |
| dout_o | output | DATA_W | Read data or status word |
| dout_oe_o | output | 1 | Output driver enable |

## Verification
A toggle flag that advances on the wrong event gives itself away on the next busy read. That read shows the same bit 6 as the previous one, or a bit 6 that changed although the access between ended while idle, so the fault appears within one access. A stuck or late read-enable register shows up at the port in the cycle after the select change. A wrong choice between status and data corrupts the very next output word, because the expected word is compared in every cycle.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef struct packed {
    logic now;
    logic held;
    logic ended;
  } acc_t;
endpackage

// File: rtl/wcs_access_track.sv
module wcs_access_track
  import wcs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  output acc_t acc_o
);
  logic rd_q;
  logic rd_now;

  assign rd_now = ~ce_ni & ~oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_now;
  end

  assign acc_o.now   = rd_now;
  assign acc_o.held  = rd_q;
  assign acc_o.ended = rd_q & ~rd_now;

  // an access end is a single-cycle event
  p_end_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o.ended |=> !acc_o.ended);
endmodule

// File: rtl/wcs_toggle_flag.sv
module wcs_toggle_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic busy_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tog_q <= 1'b0;
    else if (adv_i && busy_i) tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;

  p_flip_on_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && busy_i) |=> (tog_q != $past(tog_q)));

  p_hold_idle_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !busy_i) |=> $stable(tog_q));
endmodule

// File: rtl/wcs_read_mux.sv
module wcs_read_mux #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              busy_i,
  input  logic              last_msb_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] array_rdata_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] dout_q;
  logic              oe_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_status
    if (i == POLL_BIT) begin : g_poll
      assign status_w[i] = ~last_msb_i;
    end else if (i == TOG_BIT) begin : g_tog
      assign status_w[i] = tog_i;
    end else begin : g_rsvd
      assign status_w[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      oe_q <= rd_i;
      if (!rd_i)       dout_q <= '0;
      else if (busy_i) dout_q <= status_w;
      else             dout_q <= array_rdata_i;
    end
  end

  assign dout_o    = dout_q;
  assign dout_oe_o = oe_q;

  p_poll_inv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i) |=> (dout_o[POLL_BIT] == ~$past(last_msb_i)));

  p_rsvd_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i) |=> (dout_o[TOG_BIT-1:0] == '0));

  p_true_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !busy_i) |=> (dout_o == $past(array_rdata_i)));
endmodule

// File: rtl/poll_status_resp.sv
module poll_status_resp
  import wcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              busy_i,
  input  logic              last_msb_i,
  input  logic [DATA_W-1:0] array_rdata_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o
);
  acc_t acc;
  logic tog;

  wcs_access_track u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_ni  (ce_ni),
    .oe_ni  (oe_ni),
    .acc_o  (acc)
  );

  wcs_toggle_flag u_tog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (acc.ended),
    .busy_i (busy_i),
    .tog_o  (tog)
  );

  wcs_read_mux #(.DATA_W(DATA_W)) u_mux (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_i          (acc.now),
    .busy_i        (busy_i),
    .last_msb_i    (last_msb_i),
    .tog_i         (tog),
    .array_rdata_i (array_rdata_i),
    .dout_o        (dout_o),
    .dout_oe_o     (dout_oe_o)
  );

  p_oe_on_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni) |=> dout_oe_o);

  p_oe_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |=> !dout_oe_o);

  p_quiet_bus_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_oe_o |-> (dout_o == '0));
endmodule

// File: tb/tb_poll_status_resp.sv
`timescale 1ns/1ps
module tb_poll_status_resp;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          busy = 1'b0;
  logic          lmsb = 1'b0;
  logic [DW-1:0] ardata = '0;
  logic [DW-1:0] dout;
  logic          doe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  poll_status_resp #(.DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n),
    .busy_i(busy), .last_msb_i(lmsb), .array_rdata_i(ardata),
    .dout_o(dout), .dout_oe_o(doe)
  );

  // reference model state
  bit          m_oe;
  bit          m_stat;
  bit [DW-1:0] m_data;
  bit          m_prev_rd;
  bit          m_tog;
  bit          m_tog_known;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_oe = 0; m_stat = 0; m_data = '0; m_prev_rd = 0;
    end else begin
      automatic bit rd = !ce_n && !oe_n;
      if (m_prev_rd && !rd && busy && m_tog_known) m_tog = !m_tog;
      m_oe = rd;
      m_stat = rd && busy;
      if (!rd)       m_data = '0;
      else if (busy) m_data = {~lmsb, 1'b0, 6'b0};
      else           m_data = ardata;
      m_prev_rd = rd;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(doe == m_oe, "R1 output enable", int'(doe), int'(m_oe));
      if (!m_oe)
        check(dout == '0, "R2 idle bus", int'(dout), 0);
      else if (!m_stat)
        check(dout == m_data, "R6 true data", int'(dout), int'(m_data));
      else begin
        check(dout[7] == m_data[7], "R3 polling bit", int'(dout[7]), int'(m_data[7]));
        check(dout[5:0] == 6'b0, "R5 reserved bits", int'(dout[5:0]), 0);
        if (!m_tog_known) begin
          m_tog = dout[6];
          m_tog_known = 1;
        end else
          check(dout[6] == m_tog, "R4 R7 toggle bit", int'(dout[6]), int'(m_tog));
      end
    end
  end

  task automatic rd_access(input int len, input bit via_ce, input int gap);
    @(negedge clk);
    ce_n = 0; oe_n = 0;
    repeat (len) @(negedge clk);
    if (via_ce) ce_n = 1; else oe_n = 1;
    repeat (gap - 1) @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  always @(negedge clk) ardata <= DW'($urandom);

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R1 R2
    check(doe == 1'b0, "R1 reset enable", int'(doe), 0);
    check(dout == '0, "R2 reset data", int'(dout), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // plain reads, R6
    for (int i = 1; i <= 5; i++) rd_access(i % 3 + 1, i[0], 1 + i % 2);

    // busy, top bit written 0 then 1: R3 R4 R5
    busy = 1; lmsb = 0;
    for (int i = 0; i < 6; i++) rd_access(1 + i % 3, i[0], 1 + i % 3);
    lmsb = 1;
    for (int i = 0; i < 4; i++) rd_access(2, !i[0], 2);

    // select without output enable is no read, R1
    @(negedge clk); ce_n = 0; oe_n = 1;
    repeat (4) @(negedge clk);
    ce_n = 1; oe_n = 0;
    repeat (3) @(negedge clk);
    oe_n = 1;

    // accesses ending while idle keep the flag, R7
    busy = 0;
    for (int i = 0; i < 3; i++) rd_access(2, i[0], 1);
    busy = 1;
    rd_access(1, 0, 2);
    rd_access(3, 1, 1);

    // busy drops mid-access, R6
    @(negedge clk); ce_n = 0; oe_n = 0;
    @(negedge clk); busy = 0;
    repeat (3) @(negedge clk);
    oe_n = 1; ce_n = 1;
    @(negedge clk);

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ce_n = ($urandom % 4) == 0;
      oe_n = ($urandom % 3) == 0;
      if (($urandom % 16) == 0) busy = !busy;
      if (($urandom % 8) == 0) lmsb = !lmsb;
    end
    @(negedge clk); ce_n = 1; oe_n = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule